// File: doc/BRIEF.md
# Transfer Descriptor Table with SECDED Protection

This block keeps one transfer descriptor for each of 128 message buffers in an on-chip RAM. Each descriptor is 19 bits wide and is stored together with six check bits: five Hamming bits and one overall parity bit. A transfer engine looks up the descriptor for a buffer through the read port. The block returns the descriptor, corrected if needed, and the full start address of that buffer in system memory. The start address is the programmable base address plus the 14-bit word offset from the descriptor.

Every read is checked. Single-bit errors are corrected when correction is enabled. Detected errors set sticky flags and capture the index of the failing entry. Uncorrectable conditions raise a non-maskable event. A separate multi-bit interrupt stays disarmed until a 4-bit key is written. A bulk-clear sequence writes a valid all-zero codeword to every entry, one entry per cycle, so the table can be brought to a known state after power-up. A write-side XOR mask on the stored codeword lets test software inject errors.

Top module: `xfer_desc_table`

## Requirements
- R1: A descriptor written to entry i (entry i serves buffer i+1) is returned on `rd_desc` with `rd_valid` high exactly two clock edges after the edge that samples `rd_en`. Descriptor layout: [1:0] transfer size (bit0 header, bit1 payload), [2] transmit-request, [16:3] word offset, [18:17] spare.
- R2: `rd_start_addr` equals the base register plus the offset times 4. The base register is loaded by `cfg_base_we` and resets to 0.
- R3: `rd_skip` is 1 exactly when the size field [1:0] of the returned descriptor is 00.
- R4: With `cfg_sec_en`=1, a single flipped codeword bit is corrected. The read also sets `sb_flag` and `pe_flag`, loads `sb_addr` and `pe_addr` with the entry index, and leaves `uncorr_evt` low. Codeword layout: [18:0] data, [23:19] Hamming bits, [24] overall parity. `wr_flip` is XORed onto the codeword when it is written.
- R5: With `cfg_sec_en`=0, a single-bit error returns the uncorrected data. It still sets `sb_flag`, `sb_addr`, `pe_flag` and `pe_addr`, and it pulses `uncorr_evt` for one cycle.
- R6: Two flipped bits set `pe_flag` and `pe_addr` and pulse `uncorr_evt` whatever the value of `cfg_sec_en`. They do not set `sb_flag`.
- R7: `mbe_irq` pulses on a double-bit error only while the interrupt is armed. The interrupt is disarmed after reset. Writing key 4'b1010 arms it, and writing any other key disarms it.
- R8: A pulse on `clr_start` holds `clr_busy` high for 128 cycles. During that time every entry is written with data 0 and valid check bits, and port writes are ignored.
- R9: After reset, all flags and event outputs are 0, both captured addresses are 0 and `clr_busy` is 0. `err_flag_clr` clears `pe_flag` and `sb_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_we | input | 1 | Load base address register |
| cfg_base | input | 32 | Base address value |
| cfg_sec_en | input | 1 | Single-bit correction enable |
| cfg_lock_we | input | 1 | Write the interrupt lock key |
| cfg_lock_key | input | 4 | Lock key value |
| wr_en | input | 1 | Write a descriptor |
| wr_idx | input | 7 | Entry index for the write |
| wr_desc | input | 19 | Descriptor to write |
| wr_flip | input | 25 | Error-injection XOR mask on the codeword |
| clr_start | input | 1 | Start bulk clear |
| clr_busy | output | 1 | Bulk clear in progress |
| rd_en | input | 1 | Read request |
| rd_idx | input | 7 | Entry index for the read |
| rd_valid | output | 1 | Read result valid |
| rd_desc | output | 19 | Returned descriptor |
| rd_start_addr | output | 32 | Buffer start address |
| rd_skip | output | 1 | Size field is empty, no data to move |
| err_flag_clr | input | 1 | Clear sticky error flags |
| pe_flag | output | 1 | Any ECC error seen |
| pe_addr | output | 7 | Entry index of the latest ECC error |
| sb_flag | output | 1 | Single-bit error seen |
| sb_addr | output | 7 | Entry index of the latest single-bit error |
| uncorr_evt | output | 1 | Non-maskable uncorrectable-error event pulse |
| mbe_irq | output | 1 | Armed multi-bit error interrupt pulse |

## Verification
The bench flips a data bit, a Hamming bit and the overall parity bit in turn. A decoder with a wrong position table would mis-correct or report a double error, and one that ignores the parity bit would miss errors that hit only that bit. It also reads a single-bit error with correction off; a design that ties the event to double errors only would stay silent there. The key sequence (default, correct key, wrong key) catches an interrupt that is armed from reset or stays armed after a wrong key. The bulk-clear test counts busy cycles and writes during busy; an off-by-one counter or a write port that is not blocked would leave stale data that shows up on readback.

// File: rtl/desc_ecc_pkg.sv
package desc_ecc_pkg;
  localparam int DATA_W = 19;
  localparam int HAM_W  = 5;
  localparam int CW_W   = DATA_W + HAM_W + 1;

  // Hamming position of data bit i: the i-th non-power-of-two index from 3.
  function automatic logic [HAM_W-1:0] ham_pos(input int i);
    int n;
    n = 0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) return HAM_W'(p);
        n++;
      end
    end
    return '0;
  endfunction

  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) h = h ^ ham_pos(i);
    return h;
  endfunction

  function automatic logic [CW_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {^{h, d}, h, d};
  endfunction
endpackage

// File: rtl/desc_ram.sv
module desc_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 25,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/desc_ecc_dec.sv
module desc_ecc_dec
  import desc_ecc_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data_fix,
  output logic              single,
  output logic              dbl
);
  logic [HAM_W-1:0]  syn;
  logic              par;
  logic [DATA_W-1:0] d;

  always_comb begin
    d        = cw[DATA_W-1:0];
    syn      = cw[DATA_W +: HAM_W] ^ ham_bits(d);
    par      = ^cw;
    single   = par;
    dbl      = !par && (syn != '0);
    data_fix = d;
    if (par) begin
      for (int i = 0; i < DATA_W; i++)
        if (ham_pos(i) == syn) data_fix[i] = ~d[i];
    end
  end
endmodule

// File: rtl/desc_err_ctl.sv
module desc_err_ctl #(
  parameter int         IDX_W    = 7,
  parameter logic [3:0] LOCK_KEY = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_valid,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             single,
  input  logic             dbl,
  input  logic             sec_en,
  input  logic             flag_clr,
  input  logic             lock_we,
  input  logic [3:0]       lock_key,
  output logic             pe_flag,
  output logic [IDX_W-1:0] pe_addr,
  output logic             sb_flag,
  output logic [IDX_W-1:0] sb_addr,
  output logic             uncorr_evt,
  output logic             mbe_irq
);
  logic irq_armed;
  logic se_hit, de_hit;

  assign se_hit = chk_valid && single;
  assign de_hit = chk_valid && dbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_armed  <= 1'b0;
      pe_flag    <= 1'b0;
      sb_flag    <= 1'b0;
      pe_addr    <= '0;
      sb_addr    <= '0;
      uncorr_evt <= 1'b0;
      mbe_irq    <= 1'b0;
    end else begin
      if (lock_we) irq_armed <= (lock_key == LOCK_KEY);
      if (flag_clr) begin
        pe_flag <= 1'b0;
        sb_flag <= 1'b0;
      end
      if (se_hit || de_hit) begin
        pe_flag <= 1'b1;
        pe_addr <= chk_idx;
      end
      if (se_hit) begin
        sb_flag <= 1'b1;
        sb_addr <= chk_idx;
      end
      uncorr_evt <= de_hit || (se_hit && !sec_en);
      mbe_irq    <= de_hit && irq_armed;
    end
  end

  assert_uncorr_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    uncorr_evt |-> pe_flag);
  assert_irq_implies_event_R7: assert property (@(posedge clk) disable iff (rst)
    mbe_irq |-> uncorr_evt);
  assert_sb_implies_pe_R4: assert property (@(posedge clk) disable iff (rst)
    sb_flag |-> pe_flag);
  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !chk_valid) |=> !sb_flag);
endmodule

// File: rtl/xfer_desc_table.sv
module xfer_desc_table
  import desc_ecc_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 14,
  parameter int OFS_LSB = 3,
  parameter int WORD_SH = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_base_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_sec_en,
  input  logic              cfg_lock_we,
  input  logic [3:0]        cfg_lock_key,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_desc,
  input  logic [CW_W-1:0]   wr_flip,
  input  logic              clr_start,
  output logic              clr_busy,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_desc,
  output logic [ADDR_W-1:0] rd_start_addr,
  output logic              rd_skip,
  input  logic              err_flag_clr,
  output logic              pe_flag,
  output logic [IDX_W-1:0]  pe_addr,
  output logic              sb_flag,
  output logic [IDX_W-1:0]  sb_addr,
  output logic              uncorr_evt,
  output logic              mbe_irq
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  clr_cnt;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [CW_W-1:0]   ram_wdata;
  logic [CW_W-1:0]   ram_q;
  logic              s1_valid;
  logic [IDX_W-1:0]  s1_idx;
  logic [DATA_W-1:0] dec_fix;
  logic              dec_single, dec_dbl;
  logic [DATA_W-1:0] out_desc;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (cfg_base_we) base_q <= cfg_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy <= 1'b0;
      clr_cnt  <= '0;
    end else if (clr_busy) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (clr_cnt == IDX_W'(ENTRIES - 1)) clr_busy <= 1'b0;
    end else if (clr_start) begin
      clr_busy <= 1'b1;
      clr_cnt  <= '0;
    end
  end

  assign ram_we    = clr_busy || wr_en;
  assign ram_waddr = clr_busy ? clr_cnt : wr_idx;
  assign ram_wdata = clr_busy ? ecc_encode('0) : (ecc_encode(wr_desc) ^ wr_flip);

  desc_ram #(.DEPTH(ENTRIES), .WIDTH(CW_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(rd_en), .raddr(rd_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= rd_en;
      s1_idx   <= rd_idx;
    end
  end

  desc_ecc_dec u_dec (
    .cw(ram_q), .data_fix(dec_fix), .single(dec_single), .dbl(dec_dbl)
  );

  assign out_desc = (cfg_sec_en && dec_single) ? dec_fix : ram_q[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid      <= 1'b0;
      rd_desc       <= '0;
      rd_start_addr <= '0;
      rd_skip       <= 1'b0;
    end else begin
      rd_valid <= s1_valid;
      if (s1_valid) begin
        rd_desc       <= out_desc;
        rd_start_addr <= base_q + (ADDR_W'(out_desc[OFS_LSB +: OFS_W]) << WORD_SH);
        rd_skip       <= (out_desc[1:0] == 2'b00);
      end
    end
  end

  desc_err_ctl #(.IDX_W(IDX_W)) u_err (
    .clk(clk), .rst(rst), .chk_valid(s1_valid), .chk_idx(s1_idx),
    .single(dec_single), .dbl(dec_dbl), .sec_en(cfg_sec_en),
    .flag_clr(err_flag_clr), .lock_we(cfg_lock_we), .lock_key(cfg_lock_key),
    .pe_flag(pe_flag), .pe_addr(pe_addr), .sb_flag(sb_flag), .sb_addr(sb_addr),
    .uncorr_evt(uncorr_evt), .mbe_irq(mbe_irq)
  );

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2));
  assert_clear_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_busy) |-> $past(clr_start));
  assert_skip_matches_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_skip == (rd_desc[1:0] == 2'b00)));
endmodule

// File: tb/tb_xfer_desc_table.sv
module tb_xfer_desc_table;
  logic clk = 0, rst = 1;
  logic cfg_base_we = 0, cfg_sec_en = 1, cfg_lock_we = 0;
  logic [31:0] cfg_base = 0;
  logic [3:0] cfg_lock_key = 0;
  logic wr_en = 0, clr_start = 0, rd_en = 0, err_flag_clr = 0;
  logic [6:0] wr_idx = 0, rd_idx = 0;
  logic [18:0] wr_desc = 0;
  logic [24:0] wr_flip = 0;
  logic clr_busy, rd_valid, rd_skip, pe_flag, sb_flag, uncorr_evt, mbe_irq;
  logic [18:0] rd_desc;
  logic [31:0] rd_start_addr;
  logic [6:0] pe_addr, sb_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_desc_table dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] i, input logic [18:0] d, input logic [24:0] f);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_desc = d; wr_flip = f;
    @(negedge clk);
    wr_en = 0; wr_flip = 0;
  endtask

  task automatic rd(input logic [6:0] i);
    @(negedge clk);
    rd_en = 1; rd_idx = i;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic key(input logic [3:0] k);
    @(negedge clk);
    cfg_lock_we = 1; cfg_lock_key = k;
    @(negedge clk);
    cfg_lock_we = 0;
  endtask

  task automatic flag_clear();
    @(negedge clk);
    err_flag_clr = 1;
    @(negedge clk);
    err_flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R9 pe_flag", pe_flag, 0);
    chk("R9 sb_flag", sb_flag, 0);
    chk("R9 addrs", {pe_addr, sb_addr}, 0);
    chk("R9 busy", clr_busy, 0);
    chk("R9 events", {uncorr_evt, mbe_irq, rd_valid}, 0);
  endtask

  task automatic t_basic();
    logic [18:0] d;
    @(negedge clk);
    cfg_base_we = 1; cfg_base = 32'h2000_0000;
    @(negedge clk);
    cfg_base_we = 0;
    d = {2'b01, 14'h1234, 1'b1, 2'b11};
    wr(7'd9, d, 0);
    rd(7'd9);
    chk("R1 valid", rd_valid, 1);
    chk("R1 data", rd_desc, d);
    chk("R2 addr", rd_start_addr, 32'h2000_0000 + (32'h1234 << 2));
    chk("R3 skip low", rd_skip, 0);
    @(negedge clk);
    chk("R1 valid one cycle", rd_valid, 0);
    d = {2'b00, 14'h3FFF, 1'b0, 2'b10};
    wr(7'd127, d, 0);
    rd(7'd127);
    chk("R1 data last", rd_desc, d);
    chk("R2 addr max", rd_start_addr, 32'h2000_0000 + 32'hFFFC);
    chk("R4 no error", pe_flag, 0);
  endtask

  task automatic t_skip();
    wr(7'd0, {2'b00, 14'h0040, 1'b1, 2'b00}, 0);
    rd(7'd0);
    chk("R3 skip set", rd_skip, 1);
    chk("R3 data", rd_desc, {2'b00, 14'h0040, 1'b1, 2'b00});
  endtask

  task automatic t_single(input int bitpos, input logic [6:0] idx);
    logic [18:0] d;
    d = {2'b10, 14'h0ABC, 1'b0, 2'b01};
    flag_clear();
    wr(idx, d, 25'(1) << bitpos);
    rd(idx);
    chk($sformatf("R4 corrected bit %0d", bitpos), rd_desc, d);
    chk("R4 sb_flag", sb_flag, 1);
    chk("R4 pe_flag", pe_flag, 1);
    chk("R4 addrs", {sb_addr, pe_addr}, {idx, idx});
    chk("R4 no event", uncorr_evt, 0);
  endtask

  task automatic t_single_nocorr();
    logic [18:0] d;
    d = {2'b00, 14'h0101, 1'b1, 2'b11};
    flag_clear();
    cfg_sec_en = 0;
    wr(7'd33, d, 25'h80);
    rd(7'd33);
    chk("R5 raw data", rd_desc, d ^ 19'h80);
    chk("R5 event", uncorr_evt, 1);
    chk("R5 sb_flag", sb_flag, 1);
    chk("R5 addrs", {sb_addr, pe_addr}, {7'd33, 7'd33});
    @(negedge clk);
    chk("R5 event pulse", uncorr_evt, 0);
    cfg_sec_en = 1;
  endtask

  task automatic t_double_key();
    flag_clear();
    wr(7'd64, 19'h15555, 25'h408);
    rd(7'd64);
    chk("R6 event", uncorr_evt, 1);
    chk("R6 pe_flag", pe_flag, 1);
    chk("R6 pe_addr", pe_addr, 7'd64);
    chk("R6 no sb_flag", sb_flag, 0);
    chk("R7 disarmed after reset", mbe_irq, 0);
    key(4'b1010);
    rd(7'd64);
    chk("R7 armed irq", mbe_irq, 1);
    chk("R6 event again", uncorr_evt, 1);
    key(4'b0101);
    rd(7'd64);
    chk("R7 wrong key disarms", mbe_irq, 0);
  endtask

  task automatic t_clear();
    int cyc;
    wr(7'd5, 19'h7FFFF, 0);
    @(negedge clk);
    clr_start = 1;
    @(negedge clk);
    clr_start = 0;
    chk("R8 busy", clr_busy, 1);
    wr_en = 1; wr_idx = 7'd7; wr_desc = 19'h1F0F0;
    @(negedge clk);
    wr_en = 0;
    cyc = 2;
    while (clr_busy && cyc < 500) begin
      @(negedge clk);
      if (clr_busy) cyc++;
    end
    chk("R8 busy length", cyc, 128);
    flag_clear();
    rd(7'd5);
    chk("R8 entry 5 zero", rd_desc, 0);
    rd(7'd7);
    chk("R8 write ignored", rd_desc, 0);
    rd(7'd127);
    chk("R8 last zero", rd_desc, 0);
    chk("R8 valid ecc", pe_flag, 0);
  endtask

  task automatic t_flagclr();
    wr(7'd3, 19'h1, 25'h1);
    rd(7'd3);
    chk("R9 flag set", sb_flag, 1);
    flag_clear();
    chk("R9 flags cleared", {pe_flag, sb_flag}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_skip();
    t_single(5, 7'd12);
    t_single(21, 7'd13);
    t_single(24, 7'd14);
    t_single_nocorr();
    t_double_key();
    t_clear();
    t_flagclr();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule